// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a small register port of 16-bit words. It counts down once per half-second tick, which arrives as a one-cycle enable pulse on `tick_half`. When the count runs out, it pulses a reset request. Software keeps the timer alive with a two-word service sequence: 0x5555, then 0xAAAA, both written to the service word. Any other pattern leaves the count running.

The control word holds four things: an 8-bit timeout field, a run bit, a bit that blocks the reset request, and a low-power hold bit. The timeout field counts in half-seconds and the period is the field value plus one. The run bit cannot be cleared once set. The hold bit takes only the first control write after reset. A status word reports whether the timer has expired since the last power-on reset. That flag survives the ordinary reset that the request itself usually triggers.

The register port is a plain synchronous strobe interface with no back-pressure. A write takes effect at the clock edge that samples `reg_wr`. Read data is registered and appears one edge after `reg_rd`. The bus carries single control words rather than a data stream, so the port has no valid/ready handshake.

Top module: `keyed_wdog`

## Requirements
- R1: Word addresses are 0x0 for control, 0x2 for service and 0x4 for status. The control word reads back as timeout field [15:8], request-block [3], run [2] and low-power hold [0], with all other bits 0. The status word reads bit 1 as the timeout flag and all other bits 0. The service word reads 0. After power-on reset, all reads return 0. Read data appears one clock edge after the read strobe.
- R2: A control write that sets the run bit while the timer is stopped loads the count with the written timeout field N. The (N+1)-th following tick then expires the timer.
- R3: Writing 0x5555 and then 0xAAAA to the service word reloads the count with the current timeout field.
- R4: Any service write other than the expected next word returns the detector to waiting for 0x5555. A 0x5555 written in that case is taken as the first word.
- R5: Once set, the run bit stays set. A control write with bit 2 clear leaves it at 1, and expiry still occurs.
- R6: Only the first control write after reset sets the low-power hold bit. Later writes leave it unchanged.
- R7: While the hold bit is 1 and `lp_mode` is 1, ticks do not change the count. When the hold bit is 0, `lp_mode` has no effect.
- R8: On expiry with request-block (bit 3) clear, `rst_req` goes high for exactly RST_PULSE cycles. With request-block set, expiry raises no request.
- R9: The timeout flag is set with each reset request. It stays set through `rst_n` and is cleared only by `por_n`.
- R10: Rewriting the timeout field while the timer runs does not change the current count. The new value is loaded at the next completed service sequence and at each expiry reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset; leaves the timeout flag intact |
| por_n | input | 1 | Synchronous active-low power-on reset; clears everything |
| reg_addr | input | ADDR_W (3) | Word address of the access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Registered read data |
| tick_half | input | 1 | One-cycle half-second tick enable |
| lp_mode | input | 1 | Low-power state indication |
| rst_req | output | 1 | Reset request pulse |

## Verification
Register writes act at the edge that samples the strobe, and read data can be sampled on the falling edge that follows. A tick that expires the timer raises `rst_req` at that same edge. The bench samples it on the next falling edge and counts the request's width one cycle at a time. All stimulus is applied on falling edges, so every tick, write and read resolves at the single rising edge between two falling-edge samples. Every expected expiry is therefore a tick count known in advance from the programmed field.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // word addresses
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_SVC  = 2;
  localparam int unsigned OFS_STAT = 4;

  // service keys, in required order
  localparam logic [15:0] KEY_FIRST  = 16'h5555;
  localparam logic [15:0] KEY_SECOND = 16'hAAAA;

  // control field positions
  localparam int unsigned CF_TO_LSB = 8;
  localparam int unsigned CF_BLOCK  = 3;
  localparam int unsigned CF_RUN    = 2;
  localparam int unsigned CF_HOLD   = 0;

  // status field position
  localparam int unsigned SF_TOUT = 1;

  typedef enum logic {SEQ_WAIT_FIRST, SEQ_WAIT_SECOND} seq_state_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TO_W   = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [TO_W-1:0]   to_val,
  output logic              blk,
  output logic              run,
  output logic              hold,
  output logic              hold_lock,
  output logic              run_start
);
  // stopped timer being started by this write
  assign run_start = wr & ~run & wdata[CF_RUN];

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      to_val    <= '0;
      blk       <= 1'b0;
      run       <= 1'b0;
      hold      <= 1'b0;
      hold_lock <= 1'b0;
    end else if (wr) begin
      to_val    <= wdata[CF_TO_LSB +: TO_W];
      blk       <= wdata[CF_BLOCK];
      run       <= run | wdata[CF_RUN];
      if (!hold_lock) hold <= wdata[CF_HOLD];
      hold_lock <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              reload
);
  seq_state_t state;

  assign reload = wr && (state == SEQ_WAIT_SECOND) && (wdata == DATA_W'(KEY_SECOND));

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      state <= SEQ_WAIT_FIRST;
    end else if (wr) begin
      // any word but the first key (including a completed pair) restarts
      state <= (wdata == DATA_W'(KEY_FIRST)) ? SEQ_WAIT_SECOND : SEQ_WAIT_FIRST;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             run,
  input  logic             tick,
  input  logic             hold,
  input  logic             blk,
  output logic [CNT_W-1:0] cnt,
  output logic             req_start,
  output logic             rst_req
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] pulse_left;
  logic          step;
  logic          expire;

  assign step      = run && tick && !hold && !load;
  assign expire    = step && (cnt == '0);
  assign req_start = expire && !blk;
  assign rst_req   = (pulse_left != '0);

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (expire) begin
      cnt <= reload_val;
    end else if (step) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      pulse_left <= '0;
    end else if (req_start) begin
      pulse_left <= PW'(PULSE_CYC);
    end else if (pulse_left != '0) begin
      pulse_left <= pulse_left - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned RST_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_half,
  input  logic              lp_mode,
  output logic              rst_req
);
  localparam int unsigned TO_W = DATA_W - CF_TO_LSB;

  logic              srst_n;
  logic              wr_ctrl, wr_svc;
  logic [TO_W-1:0]   to_val;
  logic              blk, run, hold, hold_lock, run_start;
  logic              svc_reload;
  logic              load;
  logic [TO_W-1:0]   load_val;
  logic [TO_W-1:0]   cnt;
  logic              req_start;
  logic              tout_flag;
  logic [DATA_W-1:0] ctrl_view, stat_view;

  assign srst_n  = rst_n & por_n;
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_svc  = reg_wr && (reg_addr == ADDR_W'(OFS_SVC));

  wdog_ctrl_reg #(.DATA_W(DATA_W), .TO_W(TO_W)) u_ctrl (
    .clk(clk), .srst_n(srst_n), .wr(wr_ctrl), .wdata(reg_wdata),
    .to_val(to_val), .blk(blk), .run(run), .hold(hold),
    .hold_lock(hold_lock), .run_start(run_start)
  );

  wdog_key_seq #(.DATA_W(DATA_W)) u_keys (
    .clk(clk), .srst_n(srst_n), .wr(wr_svc), .wdata(reg_wdata),
    .reload(svc_reload)
  );

  assign load     = run_start | svc_reload;
  assign load_val = run_start ? reg_wdata[CF_TO_LSB +: TO_W] : to_val;

  wdog_counter #(.CNT_W(TO_W), .PULSE_CYC(RST_PULSE)) u_cnt (
    .clk(clk), .srst_n(srst_n), .load(load), .load_val(load_val),
    .reload_val(to_val), .run(run), .tick(tick_half),
    .hold(hold & lp_mode), .blk(blk), .cnt(cnt),
    .req_start(req_start), .rst_req(rst_req)
  );

  // timeout flag survives the system reset
  always_ff @(posedge clk) begin
    if (!por_n)         tout_flag <= 1'b0;
    else if (req_start) tout_flag <= 1'b1;
  end

  always_comb begin
    ctrl_view                        = '0;
    ctrl_view[CF_TO_LSB +: TO_W]     = to_val;
    ctrl_view[CF_BLOCK]              = blk;
    ctrl_view[CF_RUN]                = run;
    ctrl_view[CF_HOLD]               = hold;
    stat_view                        = '0;
    stat_view[SF_TOUT]               = tout_flag;
  end

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_addr == ADDR_W'(OFS_CTRL))      reg_rdata <= ctrl_view;
      else if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata <= stat_view;
      else                                    reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RST_PULSE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             reg_wr,
  input logic             tick_half,
  input logic             lp_mode,
  input logic             run,
  input logic             hold,
  input logic             hold_lock,
  input logic             blk,
  input logic [CNT_W-1:0] cnt,
  input logic             tout_flag,
  input logic             rst_req
);
  // R5
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    run |=> run);

  // R6
  hold_locked_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    hold_lock |=> $stable(hold));

  // R7
  lp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (run && hold && lp_mode && tick_half && !reg_wr) |=> $stable(cnt));

  // R8
  req_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(rst_req) |-> !$past(blk));

  // R8
  generate
    if (RST_PULSE >= 2) begin : g_wide
      req_width_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(rst_req) |=> rst_req);
    end
  endgenerate

  // R9
  flag_kept_chk: assert property (@(posedge clk) disable iff (!por_n)
    tout_flag |=> tout_flag);
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(TO_W), .RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .reg_wr(reg_wr),
  .tick_half(tick_half), .lp_mode(lp_mode), .run(run), .hold(hold),
  .hold_lock(hold_lock), .blk(blk), .cnt(cnt), .tout_flag(tout_flag),
  .rst_req(rst_req)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tick_half = 1'b0;
  logic        lp_mode = 1'b0;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_wdog #(.DATA_W(16), .ADDR_W(3), .RST_PULSE(PULSE)) u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick_half(tick_half), .lp_mode(lp_mode),
    .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic do_sysrst();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_half = 1'b1;
    @(negedge clk); tick_half = 1'b0;
  endtask

  // n ticks with no request expected after any of them
  task automatic quiet_ticks(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(req, 16'(rst_req), 16'h0);
    end
  endtask

  // one tick that must expire, then measure the request width
  task automatic firing_tick(input string req);
    int width;
    tick();
    chk(req, 16'(rst_req), 16'h1);
    width = 0;
    while (rst_req && width < 50) begin
      width++;
      @(negedge clk);
    end
    chk({req, " width"}, 16'(width), 16'(PULSE));
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_por();
    chk("R1 rst_req", 16'(rst_req), 16'h0);
    rd(3'h0, d); chk("R1 ctrl reset", d, 16'h0000);
    rd(3'h4, d); chk("R1 stat reset", d, 16'h0000);
    rd(3'h2, d); chk("R1 svc read", d, 16'h0000);
  endtask

  task automatic t_expiry();
    logic [15:0] d;
    do_por();
    wr(3'h0, 16'h0304);
    rd(3'h0, d); chk("R1 ctrl readback", d, 16'h0304);
    quiet_ticks("R2 before expiry", 3);
    firing_tick("R2 R8 expiry");
    rd(3'h4, d); chk("R9 flag set", d, 16'h0002);
    rd(3'h2, d); chk("R1 svc read", d, 16'h0000);
  endtask

  task automatic t_flag_keep();
    logic [15:0] d;
    do_sysrst();
    rd(3'h4, d); chk("R9 flag after rst_n", d, 16'h0002);
    rd(3'h0, d); chk("R9 ctrl after rst_n", d, 16'h0000);
    do_por();
    rd(3'h4, d); chk("R9 flag after por_n", d, 16'h0000);
  endtask

  task automatic t_service();
    do_por();
    wr(3'h0, 16'h0304);
    quiet_ticks("R3 pre", 2);
    wr(3'h2, 16'h5555);
    wr(3'h2, 16'hAAAA);
    quiet_ticks("R3 reloaded", 3);
    firing_tick("R3 after reload");
  endtask

  task automatic t_bad_seq();
    do_por();
    wr(3'h0, 16'h0304);
    quiet_ticks("R4 pre", 2);
    wr(3'h2, 16'hAAAA);
    wr(3'h2, 16'h5555);
    wr(3'h2, 16'h1234);
    wr(3'h2, 16'hAAAA);
    quiet_ticks("R4 no reload", 1);
    firing_tick("R4 broken sequence");
    do_por();
    wr(3'h0, 16'h0304);
    quiet_ticks("R4 pre2", 2);
    wr(3'h2, 16'h5555);
    wr(3'h2, 16'h5555);
    wr(3'h2, 16'hAAAA);
    quiet_ticks("R4 repeated first key", 3);
    firing_tick("R4 after repeated key");
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    do_por();
    wr(3'h0, 16'h0304);
    wr(3'h0, 16'h0300);
    rd(3'h0, d); chk("R5 run stays", d, 16'h0304);
    quiet_ticks("R5 running", 3);
    firing_tick("R5 still expires");
  endtask

  task automatic t_hold();
    logic [15:0] d;
    do_por();
    wr(3'h0, 16'h0001);
    rd(3'h0, d); chk("R6 hold first write", d, 16'h0001);
    wr(3'h0, 16'h0304);
    rd(3'h0, d); chk("R6 hold locked at 1", d, 16'h0305);
    lp_mode = 1'b1;
    quiet_ticks("R7 frozen", 8);
    lp_mode = 1'b0;
    quiet_ticks("R7 resumed", 3);
    firing_tick("R7 expiry after resume");
    do_por();
    wr(3'h0, 16'h0000);
    wr(3'h0, 16'h0305);
    rd(3'h0, d); chk("R6 hold locked at 0", d, 16'h0304);
    lp_mode = 1'b1;
    quiet_ticks("R7 lp ignored", 3);
    firing_tick("R7 lp without hold");
    lp_mode = 1'b0;
  endtask

  task automatic t_retime();
    logic [15:0] d;
    do_por();
    wr(3'h0, 16'h0104);
    wr(3'h0, 16'h0904);
    rd(3'h0, d); chk("R10 field rewritten", d, 16'h0904);
    quiet_ticks("R10 old count", 1);
    firing_tick("R10 old count expiry");
    wr(3'h2, 16'h5555);
    wr(3'h2, 16'hAAAA);
    quiet_ticks("R10 new count", 9);
    firing_tick("R10 new period");
  endtask

  task automatic t_blocked();
    logic [15:0] d;
    do_por();
    wr(3'h0, 16'h030C);
    quiet_ticks("R8 blocked", 6);
    rd(3'h4, d); chk("R8 no flag when blocked", d, 16'h0000);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_expiry();
    t_flag_keep();
    t_service();
    t_bad_seq();
    t_sticky();
    t_hold();
    t_retime();
    t_blocked();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule